// File: doc/BRIEF.md
# Baseband Burst Timing Control Register

This block turns four asynchronous control lines from a signal processor into a 6-bit timing register and two start strobes for a baseband codec. The four lines are uplink power, downlink power, calibrate and burst enable. Each line is resynchronized separately into the uplink clock domain and into the downlink clock domain. Each domain then holds three bits of the register. These are a power bit, a calibration bit and a burst-trigger bit.

The calibrate and burst-enable lines are shared by the two paths. Each path sees them only while its own power line is high. If both power lines are high, both paths follow the shared lines. A rising edge of a path's trigger bit produces one strobe, one clock cycle wide, in that path's clock domain. On the uplink side the strobe starts the emission of one burst. On the downlink side it starts moving received data toward the processor.

Each domain has its own active-low reset. A reset clears that domain's three bits. After a reset, no strobe is produced until the synchronizer has delivered a full sample.

Top module: `burst_timing_ctrl`

## Requirements
- R1: While a domain's reset is low, its three register bits and its strobe are 0. The bit layout of `tmr_reg` is: bit5 uplink power, bit4 uplink calibrate, bit3 uplink send, bit2 downlink power, bit1 downlink calibrate, bit0 downlink receive.
- R2: After SYNC_STAGES+1 edges of the uplink clock, bit5 equals `up_on_in`. After the same number of edges of the downlink clock, bit2 equals `dn_on_in`.
- R3: Bit4 equals `cal_in` AND `up_on_in`. Bit1 equals `cal_in` AND `dn_on_in`. While a path's power bit is 0, its calibrate bit is 0.
- R4: Bit3 equals `burst_in` AND `up_on_in`. Bit0 equals `burst_in` AND `dn_on_in`. While a path's power bit is 0, its trigger bit is 0.
- R5: Each 0-to-1 change of bit3 gives exactly one `ul_burst_start` pulse, one uplink clock wide. Holding bit3 at 1 gives no further pulse.
- R6: Each 0-to-1 change of bit0 gives exactly one `dl_rx_start` pulse, one downlink clock wide. Holding bit0 at 1 gives no further pulse.
- R7: A reset of one domain leaves the other domain's bits and strobe unaffected.
- R8: If a trigger input is held high across a domain reset, no strobe is produced when that reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ul_clk | input | 1 | Uplink domain clock |
| ul_rst_n | input | 1 | Uplink domain reset, active low |
| dl_clk | input | 1 | Downlink domain clock |
| dl_rst_n | input | 1 | Downlink domain reset, active low |
| up_on_in | input | 1 | Asynchronous uplink power request |
| dn_on_in | input | 1 | Asynchronous downlink power request |
| cal_in | input | 1 | Asynchronous shared calibrate request |
| burst_in | input | 1 | Asynchronous shared burst enable |
| tmr_reg | output | 6 | Timing register contents |
| ul_burst_start | output | 1 | Single-cycle uplink burst start strobe |
| dl_rx_start | output | 1 | Single-cycle downlink transfer start strobe |

## Verification
The bench steps through changes of the shared lines and checks how each path qualifies them. It covers three cases:
- Calibrate or enable raised with neither path powered. A design that ignored the power gating would set bits in the wrong path.
- Enable held high over many cycles. A design that triggered on the level instead of the edge would count extra strobes.
- Enable held high while one domain is reset. A design without the post-reset arming would fire a false burst when the reset is released. A design that shared resets between the domains would clear the other path's bits.

// File: rtl/burst_timing_ctrl.sv
module burst_timing_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       ul_clk,
  input  logic       ul_rst_n,
  input  logic       dl_clk,
  input  logic       dl_rst_n,
  input  logic       up_on_in,
  input  logic       dn_on_in,
  input  logic       cal_in,
  input  logic       burst_in,
  output logic [5:0] tmr_reg,
  output logic       ul_burst_start,
  output logic       dl_rx_start
);

  localparam int ARM_DEPTH = SYNC_STAGES + 2;

  // per-domain sample: {power, calibrate, enable}
  logic [2:0] ul_sync [SYNC_STAGES];
  logic [2:0] dl_sync [SYNC_STAGES];
  logic [2:0] ul_s, dl_s;
  logic [2:0] ul_bits, dl_bits;
  logic       ul_send_q, dl_rec_q;
  logic [ARM_DEPTH-1:0] ul_arm, dl_arm;

  assign ul_s = ul_sync[SYNC_STAGES-1];
  assign dl_s = dl_sync[SYNC_STAGES-1];

  always_ff @(posedge ul_clk or negedge ul_rst_n) begin
    if (!ul_rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) ul_sync[i] <= '0;
      ul_bits   <= '0;
      ul_send_q <= 1'b0;
      ul_arm    <= '0;
    end else begin
      ul_sync[0] <= {up_on_in, cal_in, burst_in};
      for (int i = 1; i < SYNC_STAGES; i++) ul_sync[i] <= ul_sync[i-1];
      ul_bits   <= {ul_s[2], ul_s[2] & ul_s[1], ul_s[2] & ul_s[0]};
      ul_send_q <= ul_bits[0];
      ul_arm    <= {ul_arm[ARM_DEPTH-2:0], 1'b1};
    end
  end

  always_ff @(posedge dl_clk or negedge dl_rst_n) begin
    if (!dl_rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) dl_sync[i] <= '0;
      dl_bits  <= '0;
      dl_rec_q <= 1'b0;
      dl_arm   <= '0;
    end else begin
      dl_sync[0] <= {dn_on_in, cal_in, burst_in};
      for (int i = 1; i < SYNC_STAGES; i++) dl_sync[i] <= dl_sync[i-1];
      dl_bits  <= {dl_s[2], dl_s[2] & dl_s[1], dl_s[2] & dl_s[0]};
      dl_rec_q <= dl_bits[0];
      dl_arm   <= {dl_arm[ARM_DEPTH-2:0], 1'b1};
    end
  end

  assign tmr_reg        = {ul_bits, dl_bits};
  assign ul_burst_start = ul_arm[ARM_DEPTH-1] & ul_bits[0] & ~ul_send_q;
  assign dl_rx_start    = dl_arm[ARM_DEPTH-1] & dl_bits[0] & ~dl_rec_q;

  p_ul_pulse_single_r5: assert property (@(posedge ul_clk) disable iff (!ul_rst_n)
    ul_burst_start |=> !ul_burst_start);
  p_ul_pulse_edge_r5: assert property (@(posedge ul_clk) disable iff (!ul_rst_n)
    ul_burst_start |-> (tmr_reg[3] && !$past(tmr_reg[3])));
  p_dl_pulse_single_r6: assert property (@(posedge dl_clk) disable iff (!dl_rst_n)
    dl_rx_start |=> !dl_rx_start);
  p_dl_pulse_edge_r6: assert property (@(posedge dl_clk) disable iff (!dl_rst_n)
    dl_rx_start |-> (tmr_reg[0] && !$past(tmr_reg[0])));
  p_ul_gate_r3: assert property (@(posedge ul_clk) disable iff (!ul_rst_n)
    !tmr_reg[5] |-> (!tmr_reg[4] && !tmr_reg[3]));
  p_dl_gate_r4: assert property (@(posedge dl_clk) disable iff (!dl_rst_n)
    !tmr_reg[2] |-> (!tmr_reg[1] && !tmr_reg[0]));

endmodule

// File: tb/tb_burst_timing_ctrl.sv
module tb_burst_timing_ctrl;
  logic ul_clk = 0, dl_clk = 0, ul_rst_n = 0, dl_rst_n = 0;
  logic up_on_in = 0, dn_on_in = 0, cal_in = 0, burst_in = 0;
  logic [5:0] tmr_reg;
  logic ul_burst_start, dl_rx_start;
  int total = 0, bad = 0, ul_cnt = 0, dl_cnt = 0;

  burst_timing_ctrl dut (.*);

  always #4 ul_clk = ~ul_clk;
  initial begin #3; forever #4 dl_clk = ~dl_clk; end

  always @(posedge ul_clk) if (ul_burst_start) ul_cnt++;
  always @(posedge dl_clk) if (dl_rx_start) dl_cnt++;

  // {up_on, dn_on, cal, burst, expected tmr_reg}
  localparam logic [9:0] VEC [15] = '{
    {4'b0000, 6'b000000}, {4'b1000, 6'b100000}, {4'b1010, 6'b110000},
    {4'b1011, 6'b111000}, {4'b1011, 6'b111000}, {4'b1001, 6'b101000},
    {4'b1000, 6'b100000}, {4'b1001, 6'b101000}, {4'b0101, 6'b000101},
    {4'b0111, 6'b000111}, {4'b1111, 6'b111111}, {4'b1100, 6'b100100},
    {4'b0010, 6'b000000}, {4'b0001, 6'b000000}, {4'b0000, 6'b000000}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v);
    @(posedge ul_clk); #2;
    {up_on_in, dn_on_in, cal_in, burst_in} = v;
    repeat (6) @(posedge ul_clk);
    @(negedge ul_clk);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] prev;
    int eu, ed, u0, d0;
    repeat (3) @(negedge ul_clk);
    chk(tmr_reg == 6'b0 && !ul_burst_start && !dl_rx_start, "R1 reset state", tmr_reg, 0);
    ul_rst_n = 1; dl_rst_n = 1;
    repeat (6) @(negedge ul_clk);
    chk(tmr_reg == 6'b0 && ul_cnt == 0 && dl_cnt == 0, "R1 after release", tmr_reg, 0);

    prev = 6'b0; eu = 0; ed = 0;
    for (int i = 0; i < 15; i++) begin
      drive(VEC[i][9:6]);
      if (VEC[i][3] && !prev[3]) eu++;
      if (VEC[i][0] && !prev[0]) ed++;
      prev = VEC[i][5:0];
      chk(tmr_reg == VEC[i][5:0], $sformatf("R2/R3/R4 vector %0d", i), tmr_reg, VEC[i][5:0]);
      chk(ul_cnt == eu, $sformatf("R5 uplink strobes vector %0d", i), ul_cnt, eu);
      chk(dl_cnt == ed, $sformatf("R6 downlink strobes vector %0d", i), dl_cnt, ed);
    end

    // long hold of enable: no retrigger
    drive(4'b1111);
    u0 = ul_cnt; d0 = dl_cnt;
    repeat (40) @(negedge ul_clk);
    chk(ul_cnt == u0, "R5 level hold", ul_cnt, u0);
    chk(dl_cnt == d0, "R6 level hold", dl_cnt, d0);

    // downlink reset only
    dl_rst_n = 0;
    repeat (3) @(negedge ul_clk);
    chk(tmr_reg == 6'b111000, "R7 uplink kept in downlink reset", tmr_reg, 6'b111000);
    chk(!dl_rx_start, "R1 downlink strobe in reset", dl_rx_start, 0);
    dl_rst_n = 1;
    repeat (10) @(negedge ul_clk);
    chk(tmr_reg == 6'b111111, "R2 downlink restore", tmr_reg, 6'b111111);
    chk(dl_cnt == d0, "R8 downlink no strobe after reset", dl_cnt, d0);
    chk(ul_cnt == u0, "R7 uplink strobes unaffected", ul_cnt, u0);

    // uplink reset only
    ul_rst_n = 0;
    repeat (3) @(negedge ul_clk);
    chk(tmr_reg == 6'b000111, "R7 downlink kept in uplink reset", tmr_reg, 6'b000111);
    ul_rst_n = 1;
    repeat (10) @(negedge ul_clk);
    chk(tmr_reg == 6'b111111, "R2 uplink restore", tmr_reg, 6'b111111);
    chk(ul_cnt == u0, "R8 uplink no strobe after reset", ul_cnt, u0);
    chk(dl_cnt == d0, "R7 downlink strobes unaffected", dl_cnt, d0);

    // fresh edge after reset still triggers
    drive(4'b1110);
    drive(4'b1111);
    chk(ul_cnt == u0 + 1, "R5 edge after reset", ul_cnt, u0 + 1);
    chk(dl_cnt == d0 + 1, "R6 edge after reset", dl_cnt, d0 + 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule